// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This block takes one maintenance request for a byte range (a start address, an exclusive end address and an operation: invalidate, clean or flush). It turns that request into a series of commands for an outer cache controller. The range is aligned to 32-byte lines. The aligned range is then cut into chunks, and each chunk becomes a range command with an inclusive first-line and last-line address. Only one command is outstanding at a time. Each command is held on the command port until the cache side returns a one-cycle done.

A chunk never crosses a 4 KiB page boundary and never covers more than a configurable number of bytes. This bounds how long the cache side stalls on any single command. For invalidate, a line that is only partly covered by the request gets a single-line clean-and-invalidate instead of a plain invalidate, so that the bytes outside the range are not lost. A write-through override input, sampled when the request is accepted, removes every clean step. The request is reported finished only after the last command has completed, so the busy flag can serve as a completion barrier.

Top module: `cache_range_seq`

## Requirements
- R1: Every command carries line-aligned addresses (low 5 bits zero) with start not above end. Command op encodings are 0 = single-line clean-and-invalidate (start equals end), 1 = range clean, 2 = range invalidate. For range commands the end field is the chunk's exclusive end minus 32.
- R2: Request op encodings are 0 = invalidate, 1 = clean, 2 = flush. For clean and flush, the start is rounded down and the exclusive end is rounded up to a 32-byte boundary before splitting.
- R3: No range command spans two 4 KiB pages. Each chunk ends at the first page boundary above its start if that comes before the other limits.
- R4: No chunk covers more than MAX_CHUNK bytes (default 1024). Chunks follow one another without gaps until the aligned end is reached.
- R5: For invalidate with a start that is not line-aligned, the first command is a single-line clean-and-invalidate of the line holding the start, and range commands begin at the next line.
- R6: For invalidate with a misaligned end, a single-line clean-and-invalidate of the line holding the end follows any start-line command. Range commands then stop at that line's base.
- R7: With the write-through override set at acceptance, a clean request issues no command, and a flush issues only range invalidates.
- R8: For flush without override, each chunk issues a range clean followed directly by a range invalidate with identical start and end.
- R9: When the aligned start is not below the aligned end, no range command is issued and the request completes. Request op 3 is accepted and issues no command.
- R10: reqReady is high only while busy is low. While cmdValid is high without cmdDone, the command fields stay stable. No new command appears before done. busy drops on the second rising edge after the final done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle; request taken when both high |
| reqOp | input | 2 | Request operation (R2 encoding) |
| reqStart | input | ADDR_W | First byte of the range |
| reqEnd | input | ADDR_W | Byte after the range (exclusive) |
| wtOverride | input | 1 | Write-through override, sampled at acceptance |
| cmdValid | output | 1 | Command presented to the cache |
| cmdOp | output | 2 | Command operation (R1 encoding) |
| cmdStart | output | ADDR_W | First line address of the command |
| cmdEnd | output | ADDR_W | Last line address of the command (inclusive) |
| cmdDone | input | 1 | One-cycle completion of the presented command |
| busy | output | 1 | Request in progress |

## Verification
A corrupted chunk pointer or end register shows up on the very next command as a wrong start or end address, or as a chunk that crosses a page or exceeds the cap. It can also show up as a wrong command count once busy falls. A wrong control state shows as a missing or extra clean step in a flush, a single-line command where a range was due, or busy falling before or long after the final done. Each of these appears at the command port within one command handshake of the fault.

// File: rtl/cmseq_pkg.sv
package cmseq_pkg;
  typedef enum logic [1:0] {
    REQ_INV   = 2'd0,
    REQ_CLEAN = 2'd1,
    REQ_FLUSH = 2'd2,
    REQ_NONE  = 2'd3
  } reqOp_t;

  typedef enum logic [1:0] {
    CMD_LINE_CI     = 2'd0,
    CMD_RANGE_CLEAN = 2'd1,
    CMD_RANGE_INV   = 2'd2
  } cmdOp_t;

  typedef enum logic [1:0] {
    SEL_HEAD  = 2'd0,
    SEL_TAIL  = 2'd1,
    SEL_CHUNK = 2'd2
  } addrSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     clrHead;
    logic     clrTail;
    logic     advance;
    addrSel_t sel;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic headNeed;
    logic tailNeed;
    logic more;
  } dpStat_t;
endpackage

// File: rtl/crs_datapath.sv
module crs_datapath
  import cmseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int MAX_CHUNK  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqStart,
  input  logic [ADDR_W-1:0] reqEnd,
  output dpStat_t           stat,
  output logic [ADDR_W-1:0] cmdStart,
  output logic [ADDR_W-1:0] cmdEnd
);
  localparam int EW = ADDR_W + 1;
  localparam int LB = $clog2(LINE_BYTES);
  localparam logic [EW-1:0] LINE_MASK = EW'(LINE_BYTES - 1);
  localparam logic [EW-1:0] PAGE_MASK = EW'(PAGE_BYTES - 1);
  localparam logic [EW-1:0] LINE_INC  = EW'(LINE_BYTES);
  localparam logic [EW-1:0] CAP_INC   = EW'(MAX_CHUNK);

  logic [EW-1:0]     curS, endR;
  logic [ADDR_W-1:0] headLine, tailLine;
  logic              headNeed, tailNeed;

  logic [EW-1:0] sExt, eExt, sDown, eDown, sIn, eIn;
  logic          sMis, eMis, isInv;

  always_comb begin
    sExt  = {1'b0, reqStart};
    eExt  = {1'b0, reqEnd};
    sMis  = |reqStart[LB-1:0];
    eMis  = |reqEnd[LB-1:0];
    isInv = (reqOp == REQ_INV);
    sDown = sExt & ~LINE_MASK;
    eDown = eExt & ~LINE_MASK;
    if (isInv) begin
      sIn = sMis ? sDown + LINE_INC : sExt;
      eIn = eDown;
    end else begin
      sIn = sDown;
      eIn = eMis ? eDown + LINE_INC : eExt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curS     <= '0;
      endR     <= '0;
      headLine <= '0;
      tailLine <= '0;
      headNeed <= 1'b0;
      tailNeed <= 1'b0;
    end else if (ctl.load) begin
      curS     <= sIn;
      endR     <= eIn;
      headLine <= sDown[ADDR_W-1:0];
      tailLine <= eDown[ADDR_W-1:0];
      headNeed <= isInv && sMis;
      tailNeed <= isInv && eMis;
    end else begin
      if (ctl.clrHead) headNeed <= 1'b0;
      if (ctl.clrTail) tailNeed <= 1'b0;
      if (ctl.advance) curS <= chunkEnd;
    end
  end

  // chunk end: smallest of aligned end, size cap, next page boundary
  logic [EW-1:0] capEnd, pageEnd, chunkEnd, lastLine;
  always_comb begin
    capEnd   = curS + CAP_INC;
    pageEnd  = (curS | PAGE_MASK) + EW'(1);
    chunkEnd = endR;
    if (chunkEnd > capEnd)  chunkEnd = capEnd;
    if (chunkEnd > pageEnd) chunkEnd = pageEnd;
    lastLine = chunkEnd - LINE_INC;
  end

  always_comb begin
    unique case (ctl.sel)
      SEL_HEAD: begin cmdStart = headLine; cmdEnd = headLine; end
      SEL_TAIL: begin cmdStart = tailLine; cmdEnd = tailLine; end
      default:  begin cmdStart = curS[ADDR_W-1:0]; cmdEnd = lastLine[ADDR_W-1:0]; end
    endcase
  end

  assign stat.headNeed = headNeed;
  assign stat.tailNeed = tailNeed;
  assign stat.more     = curS < endR;
endmodule

// File: rtl/crs_ctrl.sv
module crs_ctrl
  import cmseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       wtOverride,
  input  dpStat_t    stat,
  input  logic       cmdDone,
  output dpCtrl_t    ctl,
  output logic       reqReady,
  output logic       busy,
  output logic       cmdValid,
  output logic [1:0] cmdOp
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_PICK, ST_HEAD, ST_TAIL, ST_CLN, ST_INV
  } state_t;

  state_t     state, nxt;
  logic [1:0] opR;
  logic       wtR;
  logic       doClean, doInv;

  assign doClean = !wtR && (opR == REQ_CLEAN || opR == REQ_FLUSH);
  assign doInv   = (opR == REQ_INV) || (opR == REQ_FLUSH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opR   <= REQ_NONE;
      wtR   <= 1'b0;
    end else begin
      state <= nxt;
      if (ctl.load) begin
        opR <= reqOp;
        wtR <= wtOverride;
      end
    end
  end

  always_comb begin
    ctl     = '0;
    ctl.sel = SEL_CHUNK;
    nxt     = state;
    cmdOp   = CMD_RANGE_INV;
    unique case (state)
      ST_IDLE: if (reqValid) begin ctl.load = 1'b1; nxt = ST_PICK; end
      ST_PICK: begin
        if (stat.headNeed)              nxt = ST_HEAD;
        else if (stat.tailNeed)         nxt = ST_TAIL;
        else if (stat.more && doClean)  nxt = ST_CLN;
        else if (stat.more && doInv)    nxt = ST_INV;
        else                            nxt = ST_IDLE;
      end
      ST_HEAD: begin
        ctl.sel = SEL_HEAD;
        cmdOp   = CMD_LINE_CI;
        if (cmdDone) begin ctl.clrHead = 1'b1; nxt = ST_PICK; end
      end
      ST_TAIL: begin
        ctl.sel = SEL_TAIL;
        cmdOp   = CMD_LINE_CI;
        if (cmdDone) begin ctl.clrTail = 1'b1; nxt = ST_PICK; end
      end
      ST_CLN: begin
        cmdOp = CMD_RANGE_CLEAN;
        if (cmdDone) begin
          if (doInv) nxt = ST_INV;
          else begin ctl.advance = 1'b1; nxt = ST_PICK; end
        end
      end
      ST_INV: if (cmdDone) begin ctl.advance = 1'b1; nxt = ST_PICK; end
      default: nxt = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign cmdValid = (state == ST_HEAD) || (state == ST_TAIL) ||
                    (state == ST_CLN)  || (state == ST_INV);
endmodule

// File: rtl/cache_range_seq.sv
module cache_range_seq
  import cmseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int MAX_CHUNK  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqStart,
  input  logic [ADDR_W-1:0] reqEnd,
  input  logic              wtOverride,
  output logic              cmdValid,
  output logic [1:0]        cmdOp,
  output logic [ADDR_W-1:0] cmdStart,
  output logic [ADDR_W-1:0] cmdEnd,
  input  logic              cmdDone,
  output logic              busy
);
  dpCtrl_t ctl;
  dpStat_t stat;

  crs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .wtOverride(wtOverride), .stat(stat), .cmdDone(cmdDone), .ctl(ctl),
    .reqReady(reqReady), .busy(busy), .cmdValid(cmdValid), .cmdOp(cmdOp)
  );

  crs_datapath #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .MAX_CHUNK(MAX_CHUNK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqOp(reqOp),
    .reqStart(reqStart), .reqEnd(reqEnd), .stat(stat),
    .cmdStart(cmdStart), .cmdEnd(cmdEnd)
  );
endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int MAX_CHUNK  = 1024
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic [ADDR_W-1:0] cmdStart,
  input logic [ADDR_W-1:0] cmdEnd,
  input logic              cmdDone,
  input logic              busy
);
  localparam int LB = $clog2(LINE_BYTES);
  localparam int PB = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] SPAN_MAX = ADDR_W'(MAX_CHUNK - LINE_BYTES);

  p_line_aligned_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdStart[LB-1:0] == '0) && (cmdEnd[LB-1:0] == '0) && (cmdStart <= cmdEnd));

  p_same_page_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmdStart[ADDR_W-1:PB] == cmdEnd[ADDR_W-1:PB]);

  p_chunk_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdEnd - cmdStart) <= SPAN_MAX);

  p_single_line_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd0) |-> cmdStart == cmdEnd);

  p_inv_after_clean_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd2 && $past(cmdValid && cmdDone && cmdOp == 2'd1))
      |-> (cmdStart == $past(cmdStart)) && (cmdEnd == $past(cmdEnd)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdDone) |=> cmdValid && $stable(cmdOp) && $stable(cmdStart) && $stable(cmdEnd));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cmdValid && reqReady);
endmodule

bind cache_range_seq crs_checker #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
  .PAGE_BYTES(PAGE_BYTES), .MAX_CHUNK(MAX_CHUNK)
) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .cmdValid(cmdValid),
  .cmdOp(cmdOp), .cmdStart(cmdStart), .cmdEnd(cmdEnd),
  .cmdDone(cmdDone), .busy(busy)
);

// File: tb/sim_cache_range_seq.sv
`timescale 1ns/1ps
module sim_cache_range_seq;
  localparam int AW = 32;
  localparam longint LINE = 32;
  localparam longint PAGE = 4096;
  localparam longint MAXC = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = '0;
  logic [AW-1:0] reqStart = '0, reqEnd = '0;
  logic wtOverride = 1'b0;
  logic cmdDone = 1'b0;
  logic reqReady, cmdValid, busy;
  logic [1:0] cmdOp;
  logic [AW-1:0] cmdStart, cmdEnd;

  always #10 clk = ~clk;

  cache_range_seq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqStart(reqStart), .reqEnd(reqEnd), .wtOverride(wtOverride),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdStart(cmdStart), .cmdEnd(cmdEnd),
    .cmdDone(cmdDone), .busy(busy)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected command list built from the requirements
  int      expN;
  int      expOp [64];
  longint  expS  [64];
  longint  expE  [64];

  function automatic void push(input int op, input longint s, input longint e);
    if (expN < 64) begin
      expOp[expN] = op; expS[expN] = s; expE[expN] = e;
    end
    expN++;
  endfunction

  function automatic void model(input int op, input longint s0, input longint e0, input bit wt);
    longint s = s0, e = e0, ce, pe;
    bit dc, di;
    expN = 0;
    if (op == 3) return;
    if (op == 0) begin
      if (s % LINE != 0) begin push(0, s - s % LINE, s - s % LINE); s = s - s % LINE + LINE; end
      if (e % LINE != 0) begin push(0, e - e % LINE, e - e % LINE); e = e - e % LINE; end
    end else begin
      s = s - s % LINE;
      if (e % LINE != 0) e = e - e % LINE + LINE;
    end
    dc = (op == 1 || op == 2) && !wt;
    di = (op == 0 || op == 2);
    if (!(dc || di)) return;
    while (s < e) begin
      ce = e;
      if (ce > s + MAXC) ce = s + MAXC;
      pe = (s / PAGE + 1) * PAGE;
      if (ce > pe) ce = pe;
      if (dc) push(1, s, ce - LINE);
      if (di) push(2, s, ce - LINE);
      s = ce;
    end
  endfunction

  task automatic runReq(input int op, input longint s, input longint e, input bit wt,
                        input int expCnt, input string req);
    int n = 0;
    int guard = 0;
    model(op, s, e, wt);
    chk(expN == expCnt, req, "model count", expN, expCnt);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op[1:0]; reqStart = s[AW-1:0]; reqEnd = e[AW-1:0]; wtOverride = wt;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
    while (busy && guard < 20000) begin
      guard++;
      if (cmdValid) begin
        chk(reqReady == 1'b0, "R10", "ready while busy", reqReady, 0);
        if (n < expN && n < 64) begin
          chk(cmdOp == expOp[n][1:0], req, $sformatf("cmd%0d op", n), cmdOp, expOp[n]);
          chk(cmdStart == expS[n][AW-1:0], req, $sformatf("cmd%0d start", n), cmdStart, expS[n]);
          chk(cmdEnd == expE[n][AW-1:0], req, $sformatf("cmd%0d end", n), cmdEnd, expE[n]);
        end else begin
          chk(1'b0, req, "extra command", n, expN);
        end
        for (int w = 0; w < n % 3; w++) begin
          logic [AW-1:0] hs;
          hs = cmdStart;
          @(negedge clk);
          chk(cmdValid && cmdStart == hs, "R10", "held before done", cmdStart, hs);
        end
        cmdDone = 1'b1;
        @(negedge clk);
        cmdDone = 1'b0;
        n++;
        if (n == expN) begin
          chk(busy == 1'b1 && cmdValid == 1'b0, "R10", "one edge after final done", busy, 1);
          @(negedge clk);
          chk(busy == 1'b0, "R10", "second edge after final done", busy, 0);
        end
      end else begin
        @(negedge clk);
      end
    end
    chk(n == expN, req, "command count", n, expN);
    chk(reqReady == 1'b1, "R10", "ready when idle", reqReady, 1);
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] s;
    logic [31:0] e;
    logic        wt;
    logic [7:0]  cnt;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h0000_1000, 32'h0000_1400, 1'b0, 8'd1},   // R1 aligned invalidate
    '{2'd0, 32'h0000_1005, 32'h0000_1A10, 1'b0, 8'd5},   // R5 R6 R4 misaligned edges
    '{2'd1, 32'h0000_0FF0, 32'h0000_1030, 1'b0, 8'd2},   // R2 R3 clean across page
    '{2'd2, 32'h0000_2000, 32'h0000_2800, 1'b0, 8'd4},   // R8 flush pairs
    '{2'd2, 32'h0000_2000, 32'h0000_2800, 1'b1, 8'd2},   // R7 flush with override
    '{2'd1, 32'h0000_3000, 32'h0000_3100, 1'b1, 8'd0},   // R7 clean with override
    '{2'd0, 32'h0000_4000, 32'h0000_4000, 1'b0, 8'd0},   // R9 empty
    '{2'd1, 32'h0000_5001, 32'h0000_5002, 1'b0, 8'd1},   // R2 rounding to one line
    '{2'd0, 32'h0000_6005, 32'h0000_600A, 1'b0, 8'd2},   // R5 R6 both edges in one line
    '{2'd3, 32'h0000_7000, 32'h0000_8000, 1'b0, 8'd0},   // R9 op 3
    '{2'd2, 32'h0000_0E00, 32'h0000_2200, 1'b0, 8'd12}   // R3 R4 R8 long flush
  };

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R10
    chk(busy == 1'b0, "R10", "reset busy", busy, 0);
    chk(cmdValid == 1'b0, "R10", "reset cmdValid", cmdValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R10", "reset ready", reqReady, 1);
    for (int i = 0; i < NV; i++) begin
      runReq(int'(VECS[i].op), longint'(VECS[i].s), longint'(VECS[i].e), VECS[i].wt,
             int'(VECS[i].cnt), $sformatf("vec%0d", i));
    end
    // directed corner cases
    runReq(0, 64'h0000_8010, 64'h0000_8400, 1'b1, 2, "R5");   // override leaves invalidate alone
    runReq(1, 64'h0000_9000, 64'h0000_B000, 1'b0, 8, "R4");   // two full pages, cap chunks
    runReq(0, 64'h0000_C100, 64'h0000_C0E0, 1'b0, 0, "R9");   // start above end
    runReq(2, 64'h0000_DFE1, 64'h0000_E01F, 1'b0, 4, "R3");   // flush straddling page
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule